// File: doc/BRIEF.md
# Vector Operand Fetch and Destination Select Stage

This block is the front of a four-lane vector shader datapath. Each issued instruction names two source registers and a destination register. The block finds each source in one of three register banks: per-invocation inputs, scratch temporaries, or read-only constants. It can bias one source index by a signed value held in an address register. It then rearranges and optionally negates the four lanes of each source, and hands the two resulting operand vectors to an arithmetic unit outside the block. In the same cycle it presents the destination as write controls: per-lane write strobes for either the output bank or the temporary bank, plus a register number within that bank.

The arithmetic unit returns its result on `res_data` while `op_valid` is high, and the block writes it into the bank and lanes that its own write controls name. An address-load form of instruction updates the two address registers from the first operand instead of writing a destination. Input and constant banks are filled through simple load ports. The output bank can be read back through a registered port. Lanes are 16-bit two's complement values. Lane 0 (x) occupies the least significant 16 bits of every vector port, then y, z and w.

Top module: `vos_operand_stage`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `op_valid` is 0 and `op_a`, `op_b`, `wr_out_mask` and `wr_tmp_mask` are all zero. Both address registers reset to zero, so a relative access issued after reset with no address load is not shifted.
- R2: An instruction issued with `iss_valid` in cycle T produces its operands and `op_valid`=1 after the clock edge that ends cycle T+1. With default sizes, source index 0x00–0x0F reads input register n, 0x10–0x1F reads temporary n-0x10, and 0x20–0x7F reads constant n-0x20.
- R3: `iss_desc` holds the write mask in bits [3:0] (bit i is lane i), negate-A in bit 4, selectors for A in bits [12:5], negate-B in bit 13 and selectors for B in bits [21:14]. Lane i of an operand takes the source component given by the 2-bit selector at offset 2i of its field (0=x, 1=y, 2=z, 3=w).
- R4: When a source's negate bit is set, every lane of that operand is the 16-bit two's complement negation of the selected component.
- R5: `iss_areg` = 1 adds address register 0 and `iss_areg` = 2 adds address register 1, each as a signed value, to the source index. Values 0 and 3 add nothing. With `iss_swap`=0 the sum applies to source A only.
- R6: With `iss_swap`=1 the address-register offset applies to source B only, and source A uses its index unmodified.
- R7: A source whose effective index is negative or above 0x7F yields an all-zero vector.
- R8: With `op_valid`, a destination below 0x10 drives `wr_out_mask` with the descriptor mask and `wr_reg` with the index. A destination from 0x10 to 0x1F drives `wr_tmp_mask` with the mask and `wr_reg` with index-0x10. Any higher destination drives both masks to zero. Both masks are zero whenever `op_valid` is low.
- R9: In a cycle with `op_valid`, `res_data` lanes whose strobe is set are written into the selected output or temporary register, and the other lanes of that register keep their value.
- R10: An instruction with `iss_addr_load` writes address register 0 from lane x of operand A if mask bit 0 is set, and address register 1 from lane y if mask bit 1 is set. It drives no write strobes. The new values take effect for instructions issued two or more cycles later.
- R11: `obank_data` shows output register `obank_idx` one clock edge after the index is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_in_en | input | 1 | Write `ld_data` into the input bank |
| ld_in_idx | input | 4 | Input bank register number |
| ld_uni_en | input | 1 | Write `ld_data` into the constant bank |
| ld_uni_idx | input | 7 | Constant bank register number (0..95) |
| ld_data | input | 64 | Vector written by the load ports |
| iss_valid | input | 1 | Instruction issue strobe |
| iss_addr_load | input | 1 | Instruction is an address-register load |
| iss_swap | input | 1 | Inverted operand form: offset goes to source B |
| iss_areg | input | 2 | Address-register selector for the offset |
| iss_src_a | input | 7 | Source A index |
| iss_src_b | input | 7 | Source B index |
| iss_dst | input | 7 | Destination index |
| iss_desc | input | 22 | Swizzle, negate and write-mask descriptor |
| res_data | input | 64 | Result vector written back while `op_valid` is high |
| obank_idx | input | 4 | Output bank read index |
| op_valid | output | 1 | Operands and write controls are valid |
| op_a | output | 64 | Swizzled operand A |
| op_b | output | 64 | Swizzled operand B |
| wr_out_mask | output | 4 | Per-lane write strobes into the output bank |
| wr_tmp_mask | output | 4 | Per-lane write strobes into the temporary bank |
| wr_reg | output | 4 | Register number within the selected bank |
| obank_data | output | 64 | Registered output bank read data |

## Verification
The bench builds the block at its default sizes: 16-bit lanes, sixteen input, temporary and output registers, 96 constants and a 7-bit index space. At these sizes every source index, every destination index and all 256 selector patterns can be swept in full. It also sets address-register values of both signs that push effective indices past both ends of the 0x00–0x7F space, so the zero placeholder is reached from below and from above. The destination sweep pairs each index with a changing lane mask. Reading the output bank and the temporaries back afterwards shows that lanes without a strobe were preserved.

// File: rtl/vos_pkg.sv
package vos_pkg;

  localparam int LANES = 4;
  localparam int SEL_W = 2;

  typedef logic [SEL_W-1:0] lane_sel_t;

  // Descriptor word, least significant field last.
  typedef struct packed {
    lane_sel_t [LANES-1:0] sel_b;
    logic                  neg_b;
    lane_sel_t [LANES-1:0] sel_a;
    logic                  neg_a;
    logic [LANES-1:0]      wmask;
  } swz_desc_t;

  localparam int DESC_W = $bits(swz_desc_t);

  typedef enum logic [1:0] {
    SB_INPUT   = 2'd0,
    SB_TEMP    = 2'd1,
    SB_UNIFORM = 2'd2,
    SB_ZERO    = 2'd3
  } src_bank_e;

  typedef enum logic [1:0] {
    DK_OUTPUT  = 2'd0,
    DK_TEMP    = 2'd1,
    DK_DISCARD = 2'd2
  } dst_kind_e;

endpackage

// File: rtl/vos_addr_calc.sv
// Effective source index: optional signed bias, then bank classification.
module vos_addr_calc
  import vos_pkg::*;
#(
  parameter int IDX_W  = 7,
  parameter int LANE_W = 16,
  parameter int N_IN   = 16,
  parameter int N_TMP  = 16,
  parameter int N_UNI  = 96,
  parameter int IN_AW  = 4,
  parameter int TMP_AW = 4,
  parameter int UNI_AW = 7
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic              apply,
  input  logic [LANE_W-1:0] offset,
  output src_bank_e         bank,
  output logic [IN_AW-1:0]  loc_in,
  output logic [TMP_AW-1:0] loc_tmp,
  output logic [UNI_AW-1:0] loc_uni
);
  localparam int SUM_W    = ((LANE_W > IDX_W) ? LANE_W : IDX_W) + 2;
  localparam int TMP_BASE = N_IN;
  localparam int UNI_BASE = N_IN + N_TMP;
  localparam int SPAN     = UNI_BASE + N_UNI;

  logic signed [SUM_W-1:0] base_s;
  logic signed [SUM_W-1:0] off_s;
  logic signed [SUM_W-1:0] eff;

  assign base_s = $signed({{(SUM_W-IDX_W){1'b0}}, idx});
  assign off_s  = apply ? $signed({{(SUM_W-LANE_W){offset[LANE_W-1]}}, offset}) : '0;
  assign eff    = base_s + off_s;

  always_comb begin
    bank    = SB_ZERO;
    loc_in  = '0;
    loc_tmp = '0;
    loc_uni = '0;
    if (!eff[SUM_W-1]) begin
      if (eff < SUM_W'(TMP_BASE)) begin
        bank   = SB_INPUT;
        loc_in = IN_AW'(eff);
      end else if (eff < SUM_W'(UNI_BASE)) begin
        bank    = SB_TEMP;
        loc_tmp = TMP_AW'(eff - SUM_W'(TMP_BASE));
      end else if (eff < SUM_W'(SPAN)) begin
        bank    = SB_UNIFORM;
        loc_uni = UNI_AW'(eff - SUM_W'(UNI_BASE));
      end
    end
  end

endmodule

// File: rtl/vos_regbank.sv
// Behavioural vector bank: per-lane write strobes, registered read ports.
module vos_regbank #(
  parameter int DEPTH  = 16,
  parameter int LANES  = 4,
  parameter int LANE_W = 16,
  parameter int NRD    = 2,
  parameter int AW     = 4
) (
  input  logic                                clk,
  input  logic [LANES-1:0]                    we,
  input  logic [AW-1:0]                       waddr,
  input  logic [LANES-1:0][LANE_W-1:0]        wdata,
  input  logic [NRD-1:0][AW-1:0]              raddr,
  output logic [NRD-1:0][LANES-1:0][LANE_W-1:0] rdata
);
  logic [LANES-1:0][LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (we[l]) mem[waddr][l] <= wdata[l];
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    always_ff @(posedge clk) begin
      rdata[r] <= mem[raddr[r]];
    end
  end

endmodule

// File: rtl/vos_swizzle.sv
// Lane reorder followed by optional two's complement negation.
module vos_swizzle
  import vos_pkg::*;
#(
  parameter int LANE_W = 16
) (
  input  logic [LANES-1:0][LANE_W-1:0] vin,
  input  lane_sel_t [LANES-1:0]        sel,
  input  logic                         neg,
  output logic [LANES-1:0][LANE_W-1:0] vout
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] picked;
    always_comb begin
      picked  = vin[sel[g]];
      vout[g] = neg ? (~picked + LANE_W'(1)) : picked;
    end
  end

endmodule

// File: rtl/vos_operand_stage.sv
module vos_operand_stage
  import vos_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int IDX_W  = 7,
  parameter int N_IN   = 16,
  parameter int N_TMP  = 16,
  parameter int N_UNI  = 96,
  parameter int N_OUT  = 16,
  parameter int IN_AW  = (N_IN  > 1) ? $clog2(N_IN)  : 1,
  parameter int TMP_AW = (N_TMP > 1) ? $clog2(N_TMP) : 1,
  parameter int UNI_AW = (N_UNI > 1) ? $clog2(N_UNI) : 1,
  parameter int OUT_AW = (N_OUT > 1) ? $clog2(N_OUT) : 1,
  parameter int WREG_W = (OUT_AW > TMP_AW) ? OUT_AW : TMP_AW,
  parameter int VEC_W  = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_in_en,
  input  logic [IN_AW-1:0]  ld_in_idx,
  input  logic              ld_uni_en,
  input  logic [UNI_AW-1:0] ld_uni_idx,
  input  logic [VEC_W-1:0]  ld_data,
  input  logic              iss_valid,
  input  logic              iss_addr_load,
  input  logic              iss_swap,
  input  logic [1:0]        iss_areg,
  input  logic [IDX_W-1:0]  iss_src_a,
  input  logic [IDX_W-1:0]  iss_src_b,
  input  logic [IDX_W-1:0]  iss_dst,
  input  logic [DESC_W-1:0] iss_desc,
  input  logic [VEC_W-1:0]  res_data,
  input  logic [OUT_AW-1:0] obank_idx,
  output logic              op_valid,
  output logic [VEC_W-1:0]  op_a,
  output logic [VEC_W-1:0]  op_b,
  output logic [LANES-1:0]  wr_out_mask,
  output logic [LANES-1:0]  wr_tmp_mask,
  output logic [WREG_W-1:0] wr_reg,
  output logic [VEC_W-1:0]  obank_data
);
  localparam int DST_TMP_BASE = N_OUT;
  localparam int DST_END      = N_OUT + N_TMP;

  typedef logic [LANES-1:0][LANE_W-1:0] vec_t;

  // ---------------- issue side: offsets and index decode ----------------
  swz_desc_t         desc_i;
  logic [LANE_W-1:0] areg0_q, areg1_q;
  logic [LANE_W-1:0] offset;
  logic [1:0]        apply;
  logic [1:0][IDX_W-1:0] src_idx;

  assign desc_i  = swz_desc_t'(iss_desc);
  assign src_idx = {iss_src_b, iss_src_a};
  assign apply   = {iss_swap, ~iss_swap};

  always_comb begin
    case (iss_areg)
      2'd1:    offset = areg0_q;
      2'd2:    offset = areg1_q;
      default: offset = '0;
    endcase
  end

  src_bank_e             bank_c [2];
  logic [1:0][IN_AW-1:0]  rd_in;
  logic [1:0][TMP_AW-1:0] rd_tmp;
  logic [1:0][UNI_AW-1:0] rd_uni;

  for (genvar s = 0; s < 2; s++) begin : g_src
    vos_addr_calc #(
      .IDX_W (IDX_W), .LANE_W(LANE_W),
      .N_IN  (N_IN),  .N_TMP (N_TMP), .N_UNI(N_UNI),
      .IN_AW (IN_AW), .TMP_AW(TMP_AW), .UNI_AW(UNI_AW)
    ) u_addr (
      .idx    (src_idx[s]),
      .apply  (apply[s]),
      .offset (offset),
      .bank   (bank_c[s]),
      .loc_in (rd_in[s]),
      .loc_tmp(rd_tmp[s]),
      .loc_uni(rd_uni[s])
    );
  end

  dst_kind_e         dk_c;
  logic [WREG_W-1:0] dreg_c;

  always_comb begin
    if (int'(iss_dst) < DST_TMP_BASE) begin
      dk_c   = DK_OUTPUT;
      dreg_c = WREG_W'(iss_dst);
    end else if (int'(iss_dst) < DST_END) begin
      dk_c   = DK_TEMP;
      dreg_c = WREG_W'(iss_dst - IDX_W'(DST_TMP_BASE));
    end else begin
      dk_c   = DK_DISCARD;
      dreg_c = '0;
    end
  end

  // ---------------- stage 1 registers (bank reads in flight) ------------
  logic              va_q, mova_q;
  src_bank_e         bank_q [2];
  dst_kind_e         dk_q;
  logic [WREG_W-1:0] dreg_q;
  swz_desc_t         desc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      va_q   <= 1'b0;
      mova_q <= 1'b0;
      dk_q   <= DK_DISCARD;
      dreg_q <= '0;
      desc_q <= '0;
      for (int s = 0; s < 2; s++) bank_q[s] <= SB_ZERO;
    end else begin
      va_q   <= iss_valid;
      mova_q <= iss_valid & iss_addr_load;
      dk_q   <= dk_c;
      dreg_q <= dreg_c;
      desc_q <= desc_i;
      for (int s = 0; s < 2; s++) bank_q[s] <= bank_c[s];
    end
  end

  // ---------------- register banks ----------------
  logic [1:0][LANES-1:0][LANE_W-1:0] in_rd, tmp_rd, uni_rd;
  logic [0:0][LANES-1:0][LANE_W-1:0] ob_rd;
  logic [0:0][OUT_AW-1:0]            ob_addr;
  logic [LANES-1:0]                  tmp_we, out_we;

  assign tmp_we  = op_valid ? wr_tmp_mask : '0;
  assign out_we  = op_valid ? wr_out_mask : '0;
  assign ob_addr = obank_idx;

  vos_regbank #(.DEPTH(N_IN), .LANES(LANES), .LANE_W(LANE_W), .NRD(2), .AW(IN_AW)) u_in_bank (
    .clk(clk), .we({LANES{ld_in_en}}), .waddr(ld_in_idx), .wdata(ld_data),
    .raddr(rd_in), .rdata(in_rd)
  );

  vos_regbank #(.DEPTH(N_UNI), .LANES(LANES), .LANE_W(LANE_W), .NRD(2), .AW(UNI_AW)) u_uni_bank (
    .clk(clk), .we({LANES{ld_uni_en}}), .waddr(ld_uni_idx), .wdata(ld_data),
    .raddr(rd_uni), .rdata(uni_rd)
  );

  vos_regbank #(.DEPTH(N_TMP), .LANES(LANES), .LANE_W(LANE_W), .NRD(2), .AW(TMP_AW)) u_tmp_bank (
    .clk(clk), .we(tmp_we), .waddr(TMP_AW'(wr_reg)), .wdata(res_data),
    .raddr(rd_tmp), .rdata(tmp_rd)
  );

  vos_regbank #(.DEPTH(N_OUT), .LANES(LANES), .LANE_W(LANE_W), .NRD(1), .AW(OUT_AW)) u_out_bank (
    .clk(clk), .we(out_we), .waddr(OUT_AW'(wr_reg)), .wdata(res_data),
    .raddr(ob_addr), .rdata(ob_rd)
  );

  assign obank_data = ob_rd;

  // ---------------- stage 2: select, swizzle, register ----------------
  vec_t                  fetched [2];
  vec_t                  swz [2];
  lane_sel_t [LANES-1:0] sel_s [2];
  logic                  neg_s [2];

  assign sel_s[0] = desc_q.sel_a;
  assign sel_s[1] = desc_q.sel_b;
  assign neg_s[0] = desc_q.neg_a;
  assign neg_s[1] = desc_q.neg_b;

  always_comb begin
    for (int s = 0; s < 2; s++) begin
      case (bank_q[s])
        SB_INPUT:   fetched[s] = in_rd[s];
        SB_TEMP:    fetched[s] = tmp_rd[s];
        SB_UNIFORM: fetched[s] = uni_rd[s];
        default:    fetched[s] = '0;
      endcase
    end
  end

  for (genvar s = 0; s < 2; s++) begin : g_swz
    vos_swizzle #(.LANE_W(LANE_W)) u_swz (
      .vin (fetched[s]),
      .sel (sel_s[s]),
      .neg (neg_s[s]),
      .vout(swz[s])
    );
  end

  logic writes_dst;
  assign writes_dst = va_q & ~mova_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_valid    <= 1'b0;
      op_a        <= '0;
      op_b        <= '0;
      wr_out_mask <= '0;
      wr_tmp_mask <= '0;
      wr_reg      <= '0;
      areg0_q     <= '0;
      areg1_q     <= '0;
    end else begin
      op_valid    <= va_q;
      op_a        <= swz[0];
      op_b        <= swz[1];
      wr_out_mask <= (writes_dst && dk_q == DK_OUTPUT) ? desc_q.wmask : '0;
      wr_tmp_mask <= (writes_dst && dk_q == DK_TEMP)   ? desc_q.wmask : '0;
      wr_reg      <= dreg_q;
      if (mova_q && desc_q.wmask[0]) areg0_q <= swz[0][0];
      if (mova_q && desc_q.wmask[1]) areg1_q <= swz[0][1];
    end
  end

endmodule

// File: rtl/vos_operand_checker.sv
module vos_operand_checker #(
  parameter int IDX_W        = 7,
  parameter int DISCARD_BASE = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             iss_valid,
  input logic             iss_addr_load,
  input logic [IDX_W-1:0] iss_dst,
  input logic             op_valid,
  input logic [3:0]       wr_out_mask,
  input logic [3:0]       wr_tmp_mask
);

  // R1: first cycle out of reset shows an idle stage
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!op_valid && wr_out_mask == 4'd0 && wr_tmp_mask == 4'd0));

  // R2: an issue shows up as valid operands two edges later
  assert_issue_latency_R2: assert property (@(posedge clk) disable iff (rst)
    iss_valid |=> ##1 op_valid);

  // R8: no strobes without valid operands
  assert_idle_nowrite_R8: assert property (@(posedge clk) disable iff (rst)
    !op_valid |-> (wr_out_mask == 4'd0 && wr_tmp_mask == 4'd0));

  // R8: at most one bank is targeted
  assert_single_bank_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_out_mask == 4'd0) || (wr_tmp_mask == 4'd0));

  // R8: destinations past the temporary range write nothing
  assert_discard_R8: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && int'(iss_dst) >= DISCARD_BASE) |=> ##1
      (wr_out_mask == 4'd0 && wr_tmp_mask == 4'd0));

  // R10: address loads never write a destination
  assert_addr_load_nowrite_R10: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_addr_load) |=> ##1
      (wr_out_mask == 4'd0 && wr_tmp_mask == 4'd0));

endmodule

bind vos_operand_stage vos_operand_checker #(
  .IDX_W       (IDX_W),
  .DISCARD_BASE(N_OUT + N_TMP)
) i_chk (
  .clk          (clk),
  .rst          (rst),
  .iss_valid    (iss_valid),
  .iss_addr_load(iss_addr_load),
  .iss_dst      (iss_dst),
  .op_valid     (op_valid),
  .wr_out_mask  (wr_out_mask),
  .wr_tmp_mask  (wr_tmp_mask)
);

// File: tb/test_vos_operand_stage.sv
module test_vos_operand_stage;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 16;

  typedef logic [3:0][LW-1:0] vec_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_in_en = 0, ld_uni_en = 0;
  logic [3:0]  ld_in_idx = '0;
  logic [6:0]  ld_uni_idx = '0;
  logic [63:0] ld_data = '0;
  logic        iss_valid = 0, iss_addr_load = 0, iss_swap = 0;
  logic [1:0]  iss_areg = '0;
  logic [6:0]  iss_src_a = '0, iss_src_b = '0, iss_dst = '0;
  logic [21:0] iss_desc = '0;
  logic [63:0] res_data = '0;
  logic [3:0]  obank_idx = '0;
  logic        op_valid;
  logic [63:0] op_a, op_b, obank_data;
  logic [3:0]  wr_out_mask, wr_tmp_mask, wr_reg;

  vos_operand_stage i_vos_operand_stage (
    .clk(clk), .rst(rst),
    .ld_in_en(ld_in_en), .ld_in_idx(ld_in_idx),
    .ld_uni_en(ld_uni_en), .ld_uni_idx(ld_uni_idx), .ld_data(ld_data),
    .iss_valid(iss_valid), .iss_addr_load(iss_addr_load), .iss_swap(iss_swap),
    .iss_areg(iss_areg), .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
    .iss_dst(iss_dst), .iss_desc(iss_desc), .res_data(res_data),
    .obank_idx(obank_idx), .op_valid(op_valid), .op_a(op_a), .op_b(op_b),
    .wr_out_mask(wr_out_mask), .wr_tmp_mask(wr_tmp_mask), .wr_reg(wr_reg),
    .obank_data(obank_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  vec_t in_m [16];
  vec_t tmp_m [16];
  vec_t out_m [16];
  vec_t uni_m [96];
  int   a0 = 0, a1 = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic vec_t pat(int bank, int idx);
    vec_t v;
    for (int l = 0; l < 4; l++) v[l] = LW'(bank * 4099 + idx * 131 + l * 29 - 3000);
    return v;
  endfunction

  function automatic logic [21:0] mkd(logic [3:0] m, logic na, logic [7:0] sa,
                                      logic nb, logic [7:0] sb);
    return {sb, nb, sa, na, m};
  endfunction

  function automatic vec_t src_val(int e);
    if (e < 0 || e > 127) return '0;
    if (e < 16) return in_m[e];
    if (e < 32) return tmp_m[e-16];
    return uni_m[e-32];
  endfunction

  function automatic vec_t swz(vec_t v, logic [7:0] sel, logic neg);
    vec_t r;
    for (int l = 0; l < 4; l++) begin
      logic [LW-1:0] p;
      p = v[sel[2*l +: 2]];
      r[l] = neg ? LW'(-p) : p;
    end
    return r;
  endfunction

  task automatic issue(input string tag, input bit mova, input bit swap, input int areg,
                       input int sa, input int sb, input int dst,
                       input logic [21:0] desc, input logic [63:0] res);
    int off;
    vec_t ea, eb, rv;
    logic [3:0] m, eo, et;
    off = (areg == 1) ? a0 : (areg == 2) ? a1 : 0;
    ea  = swz(src_val(sa + (swap ? 0 : off)), desc[12:5], desc[4]);
    eb  = swz(src_val(sb + (swap ? off : 0)), desc[21:14], desc[13]);
    m   = desc[3:0];
    eo  = (!mova && dst < 16) ? m : 4'd0;
    et  = (!mova && dst >= 16 && dst < 32) ? m : 4'd0;
    rv  = res;
    iss_valid = 1; iss_addr_load = mova; iss_swap = swap; iss_areg = 2'(areg);
    iss_src_a = 7'(sa); iss_src_b = 7'(sb); iss_dst = 7'(dst); iss_desc = desc;
    res_data = res;
    @(negedge clk);
    iss_valid = 0;
    @(negedge clk);
    check({tag, " R2 valid"}, {63'd0, op_valid}, 64'd1);
    check({tag, " operand A"}, op_a, ea);
    check({tag, " operand B"}, op_b, eb);
    check({tag, " R8 strobes"}, {56'd0, wr_out_mask, wr_tmp_mask}, {56'd0, eo, et});
    if (eo != 0) check({tag, " R8 out reg"}, {60'd0, wr_reg}, 64'(dst));
    if (et != 0) check({tag, " R8 tmp reg"}, {60'd0, wr_reg}, 64'(dst - 16));
    @(negedge clk);
    for (int l = 0; l < 4; l++) begin
      if (eo[l]) out_m[dst][l] = rv[l];
      if (et[l]) tmp_m[dst-16][l] = rv[l];
    end
    if (mova && m[0]) a0 = int'($signed(ea[0]));
    if (mova && m[1]) a1 = int'($signed(ea[1]));
  endtask

  localparam logic [7:0] IDN = 8'hE4;

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", {63'd0, op_valid}, 64'd0);
    check("R1 reset op_a", op_a, 64'd0);
    check("R1 reset op_b", op_b, 64'd0);
    check("R1 reset strobes", {56'd0, wr_out_mask, wr_tmp_mask}, 64'd0);
    rst = 0;
    @(negedge clk);
    check("R1 post-reset valid", {63'd0, op_valid}, 64'd0);

    for (int i = 0; i < 16; i++) begin
      in_m[i] = pat(1, i);
      ld_in_en = 1; ld_in_idx = 4'(i); ld_data = in_m[i];
      @(negedge clk);
    end
    ld_in_en = 0;
    for (int i = 0; i < 96; i++) begin
      uni_m[i] = (i == 95) ? {16'hFF38, 16'd100, 16'hFFFD, 16'd5} : pat(3, i);
      ld_uni_en = 1; ld_uni_idx = 7'(i); ld_data = uni_m[i];
      @(negedge clk);
    end
    ld_uni_en = 0;

    // R1: address registers start at zero, so relative forms are unshifted
    issue("R1 areg zero", 0, 0, 1, 40, 50, 127, mkd(4'hF, 0, IDN, 0, IDN), '0);

    // fill temporaries and outputs through writeback (R8, R9)
    for (int i = 0; i < 16; i++)
      issue("R9 tmp init", 0, 0, 0, 0, 0, 16 + i, mkd(4'hF, 0, IDN, 0, IDN), pat(2, i));
    for (int i = 0; i < 16; i++)
      issue("R9 out init", 0, 0, 0, 0, 0, i, mkd(4'hF, 0, IDN, 0, IDN), pat(4, i));

    // R2: every source index through both ports
    for (int i = 0; i < 128; i++)
      issue("R2 bank map", 0, 0, 0, i, 127 - i, 127, mkd(4'hF, 0, IDN, 0, IDN), '0);

    // R3, R4: all selector patterns, both negate bits varied
    for (int k = 0; k < 256; k++)
      issue("R3 R4 swizzle", 0, 0, 0, 32 + (k % 96), (k * 7) % 128, 64 + (k % 64),
            mkd(4'(k), (k % 3) == 0, 8'(k), (k % 5) == 0, ~8'(k)), '0);

    // R10: load both address registers from constant 95 (x=5, y=-3)
    issue("R10 addr load xy", 1, 0, 0, 127, 0, 5, mkd(4'h3, 0, IDN, 0, IDN), '0);
    // R5, R6: every selector value in both operand forms
    for (int ar = 0; ar < 4; ar++)
      for (int sw = 0; sw < 2; sw++)
        issue("R5 R6 offset", 0, bit'(sw), ar, 64, 48, 127, mkd(4'hF, 0, IDN, 0, IDN), '0);

    // R10: mask gating, register 0 from z lane (100), register 1 kept
    issue("R10 addr load x only", 1, 0, 0, 127, 0, 3, mkd(4'h1, 0, 8'h02, 0, IDN), '0);
    issue("R7 above range", 0, 0, 1, 64, 3, 127, mkd(4'hF, 0, IDN, 0, IDN), '0);
    issue("R7 below range", 0, 1, 2, 9, 1, 127, mkd(4'hF, 0, IDN, 0, IDN), '0);
    // R4, R10: negated x into register 1 (-5), register 0 kept
    issue("R10 addr load y neg", 1, 0, 0, 127, 0, 20, mkd(4'h2, 1, 8'h00, 0, IDN), '0);
    issue("R10 addr load none", 1, 0, 0, 40, 0, 127, mkd(4'h0, 1, IDN, 0, IDN), '0);
    for (int s = 0; s < 128; s++)
      issue("R5 R6 R7 offset sweep", 0, bit'((s >> 1) & 1), 1 + (s % 2), s, 127 - s, 127,
            mkd(4'hF, 0, IDN, 0, IDN), '0);

    // R8, R9: every destination with a changing lane mask
    for (int d = 0; d < 128; d++)
      issue("R8 R9 dest sweep", 0, 0, 0, 33, 17, d,
            mkd(4'((d ^ (d >> 4)) & 15), 0, IDN, 0, IDN), pat(5, d));

    // R9, R11: read back the output bank
    for (int i = 0; i < 16; i++) begin
      obank_idx = 4'(i);
      @(negedge clk);
      check("R11 R9 output readback", obank_data, out_m[i]);
    end
    // R9: read back temporaries as sources
    for (int i = 0; i < 16; i++)
      issue("R9 tmp readback", 0, 0, 0, 16 + i, 31 - i, 127, mkd(4'hF, 0, IDN, 0, IDN), '0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule